// File: doc/BRIEF.md
# Register-Mapped Watchdog Timer

A watchdog peripheral on a plain 32-bit register port (address, write strobe, write data, combinational read data). Once software arms it, a down-counter clocked by the peripheral clock runs from one of sixteen power-of-two timeout lengths. Software has to restart the counter before it reaches zero by writing a fixed key to the restart register. If it does not, the block raises a system reset output.

The arm bit cannot be cleared by software; only the block reset clears it. The timeout code is sampled only when the counter is loaded, so changing it does not shorten a count that is already running. After expiry the reset output stays high for a fixed pulse and then drops. The block then stays dead, ignoring restarts, until it is reset from outside. The exponent base `BASE_EXP` is a parameter. With the default of 16, timeout code `t` gives 2^(16+t) cycles.

Top module: `wdt_timer`

## Requirements
- R1: Registers sit at byte offsets: control 0x00, timeout code 0x04 (bits 3:0, read back as written, other bits read zero), live count 0x08, restart 0x0C.
- R2: Control bit 0 is the arm bit. Writing 1 sets it. Later writes of 0 leave it at 1, and only rst_ni clears it.
- R3: A load puts 2^(BASE_EXP+code) into the counter, where code is the timeout code. The counter then drops by one each cycle, so expiry comes 2^(BASE_EXP+code)+1 edges after the load.
- R4: Writing 0x76 to the restart register while the block is armed and not expired reloads the full timeout for the current code at that clock edge.
- R5: Writing any value other than 0x76 to the restart register leaves the count running unchanged.
- R6: While the block is disarmed, the count holds (at 0 after reset), restart writes have no effect, and rst_o stays 0.
- R7: On the edge after the armed count is at zero, rst_o goes high for exactly PULSE_LEN (8) cycles. After that the count stays 0, rst_o stays 0 and restarts are ignored until rst_ni.
- R8: A write to the timeout code does not change the running count. The new code applies from the next load.
- R9: Reads of the restart register and of any offset not listed in R1 return 0. Writes to the live count register are ignored.
- R10: The write that sets the arm bit also loads the full timeout for the current code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | peripheral clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| we_i | input | 1 | register write strobe |
| addr_i | input | 8 | byte address |
| wdata_i | input | 32 | write data |
| rdata_o | output | 32 | read data for addr_i (combinational) |
| rst_o | output | 1 | system reset request |

## Verification
The bench builds the block with BASE_EXP=2, which shrinks the timeouts to 4 up to 131072 cycles. Full expiries, the eight-cycle pulse and the dead state after it all fit in a short run. Even the largest code can still be armed and read back. Random register traffic keeps codes 0 to 4, so expiries happen often, and it is mixed with directed sequences for the sticky arm bit, bad keys, a code change during a count and writes to the live count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned OFF_CTRL  = 'h00;
  localparam int unsigned OFF_TOP   = 'h04;
  localparam int unsigned OFF_COUNT = 'h08;
  localparam int unsigned OFF_KICK  = 'h0C;
  localparam int unsigned KICK_KEY  = 'h76;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int TOP_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expired_i,
  output logic              en_o,
  output logic [TOP_W-1:0]  top_o,
  output logic              load_o
);
  logic wr_ctrl, wr_top, wr_kick, arm, kick;

  assign wr_ctrl = we_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign wr_top  = we_i && (addr_i == ADDR_W'(OFF_TOP));
  assign wr_kick = we_i && (addr_i == ADDR_W'(OFF_KICK));
  assign arm     = wr_ctrl && wdata_i[0] && !en_o;
  assign kick    = wr_kick && (wdata_i == DATA_W'(KICK_KEY)) && en_o && !expired_i;
  assign load_o  = arm || kick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      top_o <= '0;
    end else begin
      if (arm)    en_o  <= 1'b1;
      if (wr_top) top_o <= wdata_i[TOP_W-1:0];
    end
  end

  assert_en_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |=> en_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int BASE_EXP  = 16,
  parameter int TOP_W     = 4,
  parameter int PULSE_LEN = 8,
  localparam int CNT_W    = BASE_EXP + (1 << TOP_W),
  localparam int PW       = $clog2(PULSE_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [TOP_W-1:0] top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o,
  output logic             rst_o
);
  logic [CNT_W-1:0] load_val;
  logic [PW-1:0]    pulse_q;
  logic             expire;

  assign load_val = CNT_W'(1) << (BASE_EXP + int'(top_i));
  assign expire   = en_i && !expired_o && (cnt_o == '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o     <= '0;
      expired_o <= 1'b0;
      pulse_q   <= '0;
    end else begin
      if (load_i) cnt_o <= load_val;
      else if (en_i && !expired_o && cnt_o != '0) cnt_o <= cnt_o - 1'b1;
      if (expire) begin
        expired_o <= 1'b1;
        pulse_q   <= PW'(PULSE_LEN);
      end else if (pulse_q != '0) begin
        pulse_q <= pulse_q - 1'b1;
      end
    end
  end

  assign rst_o = (pulse_q != '0);

  assert_hold_disarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !load_i) |=> $stable(cnt_o));
  assert_no_rst_disarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !rst_o);
  assert_dead_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expired_o |=> (expired_o && cnt_o == '0));
  assert_rst_only_expired_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> expired_o);
  assert_load_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_o != '0));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8,
  localparam int TOP_W    = 4,
  localparam int CNT_W    = BASE_EXP + (1 << TOP_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rst_o
);
  logic             en, load, expired;
  logic [TOP_W-1:0] top;
  logic [CNT_W-1:0] cnt;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TOP_W(TOP_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .expired_i(expired), .en_o(en), .top_o(top), .load_o(load)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP), .TOP_W(TOP_W), .PULSE_LEN(PULSE_LEN)) u_cnt (
    .clk_i, .rst_ni, .en_i(en), .load_i(load), .top_i(top),
    .cnt_o(cnt), .expired_o(expired), .rst_o
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(OFF_CTRL))       rdata_o = DATA_W'(en);
    else if (addr_i == ADDR_W'(OFF_TOP))   rdata_o = DATA_W'(top);
    else if (addr_i == ADDR_W'(OFF_COUNT)) rdata_o = DATA_W'(cnt);
  end
endmodule

// File: tb/wdt_timer_test.sv
`timescale 1ns/1ps
module wdt_timer_test;
  localparam int B = 2;
  logic clk = 0, rst_ni = 0, we = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic rst_o;
  int total = 0, bad = 0;
  // reference state
  bit m_en, m_exp; int m_top, m_cnt, m_pulse;

  always #2.5 clk = ~clk;

  wdt_timer #(.BASE_EXP(B)) uut (.clk_i(clk), .rst_ni, .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rst_o);

  initial begin
    #5ms;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic int exp_read(int a);
    case (a)
      'h00: return int'(m_en);
      'h04: return m_top;
      'h08: return m_cnt;
      default: return 0;
    endcase
  endfunction

  task automatic chk(string req, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic string tag_of(int a);
    case (a)
      'h00: return "R2";
      'h04: return "R1";
      'h08: return "R3";
      default: return "R9";
    endcase
  endfunction

  // apply one cycle (called at negedge), update reference, then compare at next negedge
  task automatic cyc(bit w, int a, int d);
    bit kick, arm, ld, ex;
    we = w; addr = 8'(a); wdata = d;
    kick = w && a == 'h0C && d == 'h76 && m_en && !m_exp;
    arm  = w && a == 'h00 && d[0] && !m_en;
    ld   = kick || arm;
    ex   = m_en && !m_exp && m_cnt == 0 && !ld;
    if (ld) m_cnt = 1 << (B + m_top);
    else if (m_en && !m_exp && m_cnt != 0) m_cnt--;
    if (ex) begin m_exp = 1; m_pulse = 8; end
    else if (m_pulse != 0) m_pulse--;
    if (arm) m_en = 1;
    if (w && a == 'h04) m_top = d & 'hF;
    @(posedge clk); @(negedge clk);
    chk("R7", rst_o, m_pulse != 0);
    chk(tag_of(a), rdata, exp_read(a));
    we = 0;
  endtask

  task automatic peek(int a, output int v);
    we = 0; addr = 8'(a); #0.1; v = rdata;
  endtask

  task automatic do_reset();
    rst_ni = 0; we = 0;
    m_en = 0; m_exp = 0; m_top = 0; m_cnt = 0; m_pulse = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    int v, hi;
    void'($urandom(32'd1234));
    do_reset();
    chk("R6 reset rst_o", rst_o, 0);
    peek('h00, v); chk("R2 reset ctrl", v, 0);
    peek('h08, v); chk("R6 reset count", v, 0);

    cyc(1, 'h0C, 'h76);
    repeat (20) cyc(0, 'h08, 0);
    peek('h08, v); chk("R6 disarmed count hold", v, 0);
    chk("R6 disarmed no rst", rst_o, 0);

    cyc(1, 'h04, 'hFFFF_FFF3);
    peek('h04, v); chk("R1 code readback", v, 3);
    cyc(1, 'h00, 1);
    peek('h08, v); chk("R10 arm loads", v, 32);
    cyc(1, 'h00, 0);
    peek('h00, v); chk("R2 sticky arm", v, 1);
    repeat (4) cyc(0, 'h08, 0);
    peek('h08, v); chk("R3 countdown", v, 27);
    cyc(1, 'h0C, 'h75);
    peek('h08, v); chk("R5 bad key ignored", v, 26);
    cyc(1, 'h08, 'h1000);
    peek('h08, v); chk("R9 count write ignored", v, 25);
    peek('h10, v); chk("R9 undefined read", v, 0);
    peek('h0C, v); chk("R9 restart reads zero", v, 0);
    cyc(1, 'h04, 1);
    peek('h08, v); chk("R8 code change no truncate", v, 24);
    cyc(1, 'h0C, 'h76);
    peek('h08, v); chk("R4 key reload new code", v, 8);
    hi = 0;
    for (int i = 0; i < 30; i++) begin cyc(0, 'h08, 0); hi += int'(rst_o); end
    chk("R7 pulse width", hi, 8);
    cyc(1, 'h0C, 'h76);
    peek('h08, v); chk("R7 dead ignores restart", v, 0);
    chk("R7 rst stays low", rst_o, 0);

    do_reset();
    cyc(1, 'h04, 15);
    cyc(1, 'h00, 1);
    peek('h08, v); chk("R3 largest code", v, 1 << (B + 15));

    for (int r = 0; r < 4; r++) begin
      do_reset();
      for (int i = 0; i < 1500; i++) begin
        int op = $urandom_range(0, 9);
        case (op)
          0: cyc(1, 'h04, int'($urandom) & 'hFFFF_FFF0 | int'($urandom_range(0, 4)));
          1: cyc(1, 'h00, int'($urandom));
          2, 3: cyc(1, 'h0C, ($urandom_range(0, 3) != 0) ? 'h76 : int'($urandom_range(0, 255)));
          4: cyc(1, 'h08, int'($urandom));
          5: cyc(0, int'($urandom_range(0, 31)), 0);
          default: cyc(0, 'h08, 0);
        endcase
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule